// File: doc/BRIEF.md
# Converter Result Status Register

This block keeps the 8-bit status byte that goes with a converter's output data register. Each time the converter stores a result, the block latches the value, forces it to all ones when a missing reference is detected, and records the error condition, the reference fault, the parity of the stored word and the channel that produced it. All of these fields then hold until the next store.

The status byte also carries an active-low ready flag. A result store clears the flag. Reading the data register sets it again. So does a warning strobe that fires just before the next store, which tells the host not to read. Power-down, idle and a low sync level keep the flag set for as long as they are asserted. Every output is registered, so each field changes on the clock edge that samples its cause.

Top module: `conv_status_reg`

## Requirements
- R1: After reset, `status_o` is 0x80 and `result_o` is 0.
- R2: Layout of `status_o`, from the MSB down: bit 7 is the ready flag (0 means a fresh result is present), bit 6 is error, bit 5 is no-reference, bit 4 is parity, and bits 3:0 are the channel.
- R3: A cycle with `res_wr_i` high and no forcing condition clears bit 7 on the next edge.
- R4: A cycle with `read_i` high and `res_wr_i` low sets bit 7.
- R5: A cycle with `warn_i` high and `res_wr_i` low sets bit 7.
- R6: Bit 7 is set while `pdown_i` is high, `idle_i` is high or `sync_ni` is low. This holds even in a cycle that also stores a result, and that result is still captured.
- R7: When `res_wr_i` falls in the same cycle as `read_i` or `warn_i`, the store wins and bit 7 ends at 0.
- R8: On a store, bit 6 takes the value of (`clamp_i` OR reference fault). A later store with neither condition clears it.
- R9: A reference fault is `ref_det_en_i` AND `ref_low_i` at the store. A fault sets bit 5 and stores 0xFFFFFF in `result_o`. With detection off, bit 5 is 0 and the input value is stored unchanged.
- R10: With `par_en_i` high at a store, bit 4 is the XOR of all 24 stored bits (1 when the count of ones is odd). With it low, bit 4 is 0.
- R11: Bits 3:0 take the value of `res_chan_i` from the store cycle.
- R12: Bits 6:0 and `result_o` change only on a store. Reads, warnings and forcing conditions leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| res_wr_i | input | 1 | Result store strobe |
| res_data_i | input | 24 | Result value to store |
| res_chan_i | input | 4 | Channel that produced the result |
| clamp_i | input | 1 | Result was clamped to all zeros or all ones |
| ref_low_i | input | 1 | Reference is below threshold |
| read_i | input | 1 | Data register read strobe |
| warn_i | input | 1 | Pre-update warning strobe |
| pdown_i | input | 1 | Power-down mode |
| idle_i | input | 1 | Idle mode |
| sync_ni | input | 1 | Sync, active low |
| par_en_i | input | 1 | Parity enable |
| ref_det_en_i | input | 1 | Reference detection enable |
| status_o | output | 8 | Status byte |
| result_o | output | 24 | Stored result |

## Verification
A result store can arrive in the same cycle as a data read or a warning strobe. It can also arrive while power-down, idle or sync-low is holding the ready flag. The bench creates both overlaps by driving the store strobe on the same falling edge as the competing input. It then checks that the ready flag ends cleared in the first case and set in the second, and that the other fields and the stored word still show the new result.

// File: rtl/conv_status_pkg.sv
package conv_status_pkg;
  localparam int unsigned CHAN_W = 4;

  typedef struct packed {
    logic              rdy_n;
    logic              err;
    logic              noref;
    logic              par;
    logic [CHAN_W-1:0] chan;
  } status_t;
endpackage

// File: rtl/status_parity.sv
module status_parity #(
  parameter int unsigned W = 24
) (
  input  logic [W-1:0] data_i,
  input  logic         en_i,
  output logic         par_o
);
  logic acc;
  always_comb begin
    acc = 1'b0;
    for (int i = 0; i < W; i++) acc = acc ^ data_i[i];
  end
  assign par_o = en_i & acc;
endmodule

// File: rtl/status_ready.sv
module status_ready (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic rd_i,
  input  logic warn_i,
  input  logic force_i,
  output logic rdy_n_o
);
  logic rdy_n_q;

  // force > store > read/warning
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rdy_n_q <= 1'b1;
    else if (force_i)           rdy_n_q <= 1'b1;
    else if (wr_i)              rdy_n_q <= 1'b0;
    else if (rd_i || warn_i)    rdy_n_q <= 1'b1;
  end

  assign rdy_n_o = rdy_n_q;

  // R3
  wr_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !force_i) |=> !rdy_n_o);
  // R4 R5
  rd_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_i || warn_i) && !wr_i) |=> rdy_n_o);
  // R6
  force_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_i |=> rdy_n_o);
  // R7
  collide_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && (rd_i || warn_i) && !force_i) |=> !rdy_n_o);
endmodule

// File: rtl/status_capture.sv
module status_capture
  import conv_status_pkg::*;
#(
  parameter int unsigned DATA_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CHAN_W-1:0] chan_i,
  input  logic              clamp_i,
  input  logic              ref_low_i,
  input  logic              ref_det_en_i,
  input  logic              par_en_i,
  output logic [DATA_W-1:0] data_o,
  output logic              err_o,
  output logic              noref_o,
  output logic              par_o,
  output logic [CHAN_W-1:0] chan_o
);
  logic              fault;
  logic [DATA_W-1:0] data_d;
  logic              par_d;

  assign fault  = ref_det_en_i & ref_low_i;
  assign data_d = fault ? {DATA_W{1'b1}} : data_i;

  status_parity #(.W(DATA_W)) u_par (
    .data_i (data_d),
    .en_i   (par_en_i),
    .par_o  (par_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      err_o   <= 1'b0;
      noref_o <= 1'b0;
      par_o   <= 1'b0;
      chan_o  <= '0;
    end else if (wr_i) begin
      data_o  <= data_d;
      err_o   <= clamp_i | fault;
      noref_o <= fault;
      par_o   <= par_d;
      chan_o  <= chan_i;
    end
  end

  // R8
  err_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> err_o == $past(clamp_i || (ref_det_en_i && ref_low_i)));
  // R9
  noref_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && ref_det_en_i && ref_low_i) |=> (noref_o && (&data_o)));
  // R9
  noref_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !ref_det_en_i) |=> (!noref_o && data_o == $past(data_i)));
  // R10
  par_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> par_o == ($past(par_en_i) && (^data_o)));
  // R11
  chan_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> chan_o == $past(chan_i));
  // R12
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable({data_o, err_o, noref_o, par_o, chan_o}));
endmodule

// File: rtl/conv_status_reg.sv
module conv_status_reg
  import conv_status_pkg::*;
#(
  parameter int unsigned DATA_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              res_wr_i,
  input  logic [DATA_W-1:0] res_data_i,
  input  logic [CHAN_W-1:0] res_chan_i,
  input  logic              clamp_i,
  input  logic              ref_low_i,
  input  logic              read_i,
  input  logic              warn_i,
  input  logic              pdown_i,
  input  logic              idle_i,
  input  logic              sync_ni,
  input  logic              par_en_i,
  input  logic              ref_det_en_i,
  output logic [7:0]        status_o,
  output logic [DATA_W-1:0] result_o
);
  status_t st;
  logic    force_rdy;

  assign force_rdy = pdown_i | idle_i | ~sync_ni;

  status_ready u_rdy (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (res_wr_i),
    .rd_i    (read_i),
    .warn_i  (warn_i),
    .force_i (force_rdy),
    .rdy_n_o (st.rdy_n)
  );

  status_capture #(.DATA_W(DATA_W)) u_cap (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (res_wr_i),
    .data_i       (res_data_i),
    .chan_i       (res_chan_i),
    .clamp_i      (clamp_i),
    .ref_low_i    (ref_low_i),
    .ref_det_en_i (ref_det_en_i),
    .par_en_i     (par_en_i),
    .data_o       (result_o),
    .err_o        (st.err),
    .noref_o      (st.noref),
    .par_o        (st.par),
    .chan_o       (st.chan)
  );

  assign status_o = st;

  // R9
  noref_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[5] |-> (&result_o));
  // R6
  force_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(force_rdy) |-> status_o[7]);
endmodule

// File: tb/conv_status_reg_test.sv
`timescale 1ns/1ps
module conv_status_reg_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        res_wr = 0, clamp = 0, ref_low = 0, rd = 0, warn = 0;
  logic        pdown = 0, idle = 0, sync_n = 1, par_en = 0, det_en = 0;
  logic [23:0] res_data = '0;
  logic [3:0]  res_chan = '0;
  logic [7:0]  status;
  logic [23:0] result;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  // model state
  logic        m_rdy = 1, m_err = 0, m_noref = 0, m_par = 0;
  logic [3:0]  m_chan = 0;
  logic [23:0] m_data = 0;

  always #2.5 clk = ~clk;

  conv_status_reg uut (
    .clk_i(clk), .rst_ni(rst_n), .res_wr_i(res_wr), .res_data_i(res_data),
    .res_chan_i(res_chan), .clamp_i(clamp), .ref_low_i(ref_low), .read_i(rd),
    .warn_i(warn), .pdown_i(pdown), .idle_i(idle), .sync_ni(sync_n),
    .par_en_i(par_en), .ref_det_en_i(det_en), .status_o(status), .result_o(result)
  );

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  function automatic logic [7:0] exp_status();
    return {m_rdy, m_err, m_noref, m_par, m_chan};
  endfunction

  // one cycle of stimulus, then model update and check
  task automatic step(input string req, input logic wr, input logic [23:0] d, input logic [3:0] ch,
                      input logic cl, input logic rl, input logic de, input logic pe,
                      input logic r, input logic w, input logic pd, input logic id, input logic sn);
    logic f, flt;
    @(negedge clk);
    res_wr = wr; res_data = d; res_chan = ch; clamp = cl; ref_low = rl; det_en = de; par_en = pe;
    rd = r; warn = w; pdown = pd; idle = id; sync_n = sn;
    f = pd | id | ~sn;
    if (wr) begin
      flt     = de & rl;
      m_data  = flt ? 24'hFFFFFF : d;
      m_err   = cl | flt;
      m_noref = flt;
      m_par   = pe & ($countones(m_data) % 2 == 1);
      m_chan  = ch;
    end
    if (f) m_rdy = 1;
    else if (wr) m_rdy = 0;
    else if (r | w) m_rdy = 1;
    @(negedge clk);
    res_wr = 0; rd = 0; warn = 0;
    chk(req, "status", {24'h0, status}, {24'h0, exp_status()});
    chk(req, "result", {8'h0, result}, {8'h0, m_data});
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "status", {24'h0, status}, 32'h80);
    chk("R1", "result", {8'h0, result}, 32'h0);
  endtask

  task automatic t_store_read();
    step("R2 R3 R10 R11", 1, 24'h000001, 4'h5, 0, 0, 0, 1, 0, 0, 0, 0, 1);
    chk("R2", "status literal", {24'h0, status}, 32'h15);
    step("R4 R12", 0, 24'h0ABCDE, 4'hA, 1, 0, 0, 0, 1, 0, 0, 0, 1);
    chk("R4", "status literal", {24'h0, status}, 32'h95);
  endtask

  task automatic t_warn();
    step("R3", 1, 24'h000003, 4'hF, 0, 0, 0, 1, 0, 0, 0, 0, 1);
    chk("R10", "even parity", {24'h0, status}, 32'h0F);
    step("R5 R12", 0, 24'h0, 4'h0, 0, 0, 0, 1, 0, 1, 0, 0, 1);
  endtask

  task automatic t_parity_off();
    step("R10", 1, 24'h000007, 4'h2, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    chk("R10", "parity off", {24'h0, status}, 32'h02);
  endtask

  task automatic t_clamp();
    step("R8", 1, 24'hFFFFFF, 4'h1, 1, 0, 0, 1, 0, 0, 0, 0, 1);
    chk("R8", "clamped", {24'h0, status}, 32'h41);
    step("R8", 1, 24'h000010, 4'h1, 0, 0, 0, 1, 0, 0, 0, 0, 1);
    chk("R8", "cleared", {24'h0, status}, 32'h11);
  endtask

  task automatic t_noref();
    step("R9", 1, 24'h123456, 4'h3, 0, 1, 1, 1, 0, 0, 0, 0, 1);
    chk("R9", "fault status", {24'h0, status}, 32'h63);
    step("R9", 1, 24'h123456, 4'h3, 0, 1, 0, 1, 0, 0, 0, 0, 1);
    chk("R9", "detect off data", {8'h0, result}, 32'h123456);
  endtask

  task automatic t_force();
    step("R3", 1, 24'h00A5A5, 4'h6, 0, 0, 0, 1, 0, 0, 0, 0, 1);
    step("R6 R12 pdown", 0, 24'h0, 4'h0, 1, 0, 0, 0, 0, 0, 1, 0, 1);
    step("R3", 1, 24'h000102, 4'h7, 0, 0, 0, 1, 0, 0, 0, 0, 1);
    step("R6 R12 idle", 0, 24'h0, 4'h0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
    step("R3", 1, 24'h000204, 4'h8, 0, 0, 0, 1, 0, 0, 0, 0, 1);
    step("R6 R12 sync", 0, 24'h0, 4'h0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R6 store while forced", 1, 24'h00F00F, 4'h9, 0, 0, 0, 1, 0, 0, 1, 0, 1);
    chk("R6", "ready held", {31'h0, status[7]}, 32'h1);
    step("R6 release", 0, 24'h0, 4'h0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic t_collide();
    step("R7 read", 1, 24'h00000B, 4'hC, 0, 0, 0, 1, 1, 0, 0, 0, 1);
    chk("R7", "ready after store+read", {31'h0, status[7]}, 32'h0);
    step("R5", 0, 24'h0, 4'h0, 0, 0, 0, 0, 0, 1, 0, 0, 1);
    step("R7 warn", 1, 24'h00000D, 4'hD, 0, 0, 0, 1, 0, 1, 0, 0, 1);
    chk("R7", "ready after store+warn", {31'h0, status[7]}, 32'h0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_store_read();
    t_warn();
    t_parity_off();
    t_clamp();
    t_noref();
    t_force();
    t_collide();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule